// File: doc/BRIEF.md
# Coherence Directory Controller

This block is the home directory for a small group of processors. It keeps one record per tracked memory block: a coherence state (Uncached, Shared or Exclusive), a full vector with one presence bit per processor, and the ID of the owning processor. It also holds the memory word for each block. Processors send read or write requests. The controller looks up the record and answers with a data reply, a series of invalidates, or a forward to the current owner. It then updates the record. Owners close a forward by sending an acknowledgement, which may carry the written-back data.

All messages use one output channel and leave one cycle after the cause that triggers them. The channel carries a type, a destination processor, the processor the message is on behalf of, the block number and a data word. Retries are answered on a separate small channel. A block that has a forward in flight is held busy until its acknowledgement arrives. While an invalidate sweep is running, the controller retries every request.

Top module: `dir_ctrl`

## Requirements
- R1: After reset no message and no retry is presented, every block is Uncached, and the memory word of block b holds 256 + b.
- R2: A read to an Uncached block returns, one cycle later, a data message (type 0) to the requester with the block's memory word, and the block becomes Shared with only the requester present.
- R3: A read to a Shared block returns the memory word to the requester and adds the requester to the presence vector without changing the state.
- R4: A write to an Uncached block returns the memory word to the requester, and the block becomes Exclusive with the requester as owner.
- R5: A write to a Shared block sends the data reply one cycle later. From the next cycle on, it sends one invalidate (type 1) per cycle to each present processor from the lowest index upward, skipping the writer. The writer becomes the Exclusive owner.
- R6: A read to an Exclusive block sends a forward (type 2) to the owner that names the requester. The owner's acknowledgement writes its data into memory. The block becomes Shared with both the old owner and the requester present.
- R7: A write to an Exclusive block sends a forward naming the requester to the current owner. When acknowledged, the requester becomes the owner and the block stays Exclusive.
- R8: A request to a block whose forward is not yet acknowledged gets a retry one cycle later. It produces no message and leaves the record unchanged.
- R9: A request that arrives while an invalidate sweep has targets left gets a retry.
- R10: An acknowledgement for a block with no forward outstanding has no effect on memory or the record.
- R11: While a block is Uncached its presence vector is empty, so the first write to it causes no invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqSrc | input | ID_W | Requesting processor |
| reqBlk | input | BLK_W | Requested block |
| ackValid | input | 1 | Owner acknowledgement present |
| ackBlk | input | BLK_W | Block being acknowledged |
| ackData | input | DATA_W | Written-back data (used on read forwards) |
| msgValid | output | 1 | Message present |
| msgType | output | 2 | 0 data, 1 invalidate, 2 forward |
| msgDest | output | ID_W | Destination processor |
| msgReq | output | ID_W | Requester the message acts for (the writer for invalidates) |
| msgBlk | output | BLK_W | Block concerned |
| msgData | output | DATA_W | Memory word for data messages, zero otherwise |
| rtyValid | output | 1 | Retry response present |
| rtyDest | output | ID_W | Processor told to retry |
| rtyBlk | output | BLK_W | Block of the retried request |

## Verification
Each data reply, forward and retry is due exactly one cycle after the request is sampled. A sweep puts its k-th invalidate k+1 cycles after the write that started it. An acknowledgement has no message of its own: it shows up only in the reply to the next request. The bench stamps every expected item with its due cycle when it drives the stimulus. The monitor compares at the falling edge of that cycle and reports any item that comes early, comes late or is missing. Cycles that must stay quiet, such as the slot after a write with no other sharers, are checked on their own.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    DIR_U = 2'd0,
    DIR_S = 2'd1,
    DIR_E = 2'd2
  } dirState_e;

  typedef enum logic [1:0] {
    MSG_DATA = 2'd0,
    MSG_INV  = 2'd1,
    MSG_FWD  = 2'd2
  } msgType_e;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic retry;
    logic reply;
    logic fwd;
    logic setShared;
    logic addSharer;
    logic setExcl;
    logic startScan;
    logic stepScan;
    logic ackTake;
  } dirCtl_t;

endpackage

// File: rtl/dir_ctrl_decide.sv
module dir_ctrl_decide
  import dir_pkg::*;
(
  input  logic      reqValid,
  input  logic      reqWrite,
  input  dirState_e curState,
  input  logic      curBusy,
  input  logic      scanActive,
  input  logic      ackValid,
  input  logic      ackBusy,
  output dirCtl_t   ctl
);

  always_comb begin
    ctl = '0;
    ctl.stepScan = scanActive;
    ctl.ackTake  = ackValid && ackBusy;
    if (reqValid) begin
      if (scanActive || curBusy) begin
        ctl.retry = 1'b1;
      end else begin
        unique case (curState)
          DIR_U: begin
            ctl.reply = 1'b1;
            if (reqWrite) ctl.setExcl = 1'b1;
            else          ctl.setShared = 1'b1;
          end
          DIR_S: begin
            ctl.reply = 1'b1;
            if (reqWrite) begin
              ctl.setExcl   = 1'b1;
              ctl.startScan = 1'b1;
            end else begin
              ctl.addSharer = 1'b1;
            end
          end
          default: ctl.fwd = 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/dir_ctrl_dp.sv
module dir_ctrl_dp
  import dir_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 8,
  parameter int DATA_W   = 16,
  localparam int ID_W    = $clog2(NUM_PROC),
  localparam int BLK_W   = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirCtl_t           ctl,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ID_W-1:0]   reqSrc,
  input  logic [BLK_W-1:0]  reqBlk,
  input  logic [BLK_W-1:0]  ackBlk,
  input  logic [DATA_W-1:0] ackData,
  output dirState_e         curState,
  output logic              curBusy,
  output logic              ackBusy,
  output logic              scanActive,
  output logic              msgValid,
  output msgType_e          msgType,
  output logic [ID_W-1:0]   msgDest,
  output logic [ID_W-1:0]   msgReq,
  output logic [BLK_W-1:0]  msgBlk,
  output logic [DATA_W-1:0] msgData,
  output logic              rtyValid,
  output logic [ID_W-1:0]   rtyDest,
  output logic [BLK_W-1:0]  rtyBlk
);

  dirState_e             stateQ  [NUM_BLK];
  logic [NUM_PROC-1:0]   shareQ  [NUM_BLK];
  logic [ID_W-1:0]       ownerQ  [NUM_BLK];
  logic [ID_W-1:0]       pendReqQ[NUM_BLK];
  logic [DATA_W-1:0]     memQ    [NUM_BLK];
  logic [NUM_BLK-1:0]    busyQ;
  logic [NUM_BLK-1:0]    pendWrQ;
  logic [NUM_PROC-1:0]   scanVecQ;
  logic [BLK_W-1:0]      scanBlkQ;
  logic [ID_W-1:0]       scanReqQ;

  logic [NUM_PROC-1:0]   reqBit;
  logic [ID_W-1:0]       lowIdx;

  assign reqBit     = NUM_PROC'(1) << reqSrc;
  assign curState   = stateQ[reqBlk];
  assign curBusy    = busyQ[reqBlk];
  assign ackBusy    = busyQ[ackBlk];
  assign scanActive = |scanVecQ;

  // lowest present processor still to be invalidated
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_PROC - 1; i >= 0; i--) begin
      if (scanVecQ[i]) lowIdx = ID_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BLK; b++) begin
        stateQ[b]   <= DIR_U;
        shareQ[b]   <= '0;
        ownerQ[b]   <= '0;
        pendReqQ[b] <= '0;
        memQ[b]     <= DATA_W'(256 + b);
      end
      busyQ    <= '0;
      pendWrQ  <= '0;
      scanVecQ <= '0;
      scanBlkQ <= '0;
      scanReqQ <= '0;
      msgValid <= 1'b0;
      msgType  <= MSG_DATA;
      msgDest  <= '0;
      msgReq   <= '0;
      msgBlk   <= '0;
      msgData  <= '0;
      rtyValid <= 1'b0;
      rtyDest  <= '0;
      rtyBlk   <= '0;
    end else begin
      msgValid <= 1'b0;
      rtyValid <= 1'b0;

      if (ctl.stepScan) begin
        msgValid <= 1'b1;
        msgType  <= MSG_INV;
        msgDest  <= lowIdx;
        msgReq   <= scanReqQ;
        msgBlk   <= scanBlkQ;
        msgData  <= '0;
        scanVecQ <= scanVecQ & ~(NUM_PROC'(1) << lowIdx);
      end
      if (ctl.retry) begin
        rtyValid <= 1'b1;
        rtyDest  <= reqSrc;
        rtyBlk   <= reqBlk;
      end
      if (ctl.reply) begin
        msgValid <= 1'b1;
        msgType  <= MSG_DATA;
        msgDest  <= reqSrc;
        msgReq   <= reqSrc;
        msgBlk   <= reqBlk;
        msgData  <= memQ[reqBlk];
      end
      if (ctl.fwd) begin
        msgValid         <= 1'b1;
        msgType          <= MSG_FWD;
        msgDest          <= ownerQ[reqBlk];
        msgReq           <= reqSrc;
        msgBlk           <= reqBlk;
        msgData          <= '0;
        busyQ[reqBlk]    <= 1'b1;
        pendReqQ[reqBlk] <= reqSrc;
        pendWrQ[reqBlk]  <= reqWrite;
      end
      if (ctl.setShared) begin
        stateQ[reqBlk] <= DIR_S;
        shareQ[reqBlk] <= reqBit;
      end
      if (ctl.addSharer) shareQ[reqBlk] <= shareQ[reqBlk] | reqBit;
      if (ctl.setExcl) begin
        stateQ[reqBlk] <= DIR_E;
        ownerQ[reqBlk] <= reqSrc;
        shareQ[reqBlk] <= reqBit;
      end
      if (ctl.startScan) begin
        scanVecQ <= shareQ[reqBlk] & ~reqBit;
        scanBlkQ <= reqBlk;
        scanReqQ <= reqSrc;
      end
      if (ctl.ackTake) begin
        busyQ[ackBlk] <= 1'b0;
        if (pendWrQ[ackBlk]) begin
          ownerQ[ackBlk] <= pendReqQ[ackBlk];
          shareQ[ackBlk] <= NUM_PROC'(1) << pendReqQ[ackBlk];
        end else begin
          memQ[ackBlk]   <= ackData;
          stateQ[ackBlk] <= DIR_S;
          shareQ[ackBlk] <= (NUM_PROC'(1) << ownerQ[ackBlk])
                          | (NUM_PROC'(1) << pendReqQ[ackBlk]);
        end
      end
    end
  end

  // ---------------- assertions ----------------
  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blkChk
    assert_uncached_empty_R11: assert property (@(posedge clk) disable iff (!rstN)
      stateQ[b] == DIR_U |-> shareQ[b] == '0);
    assert_excl_single_R7: assert property (@(posedge clk) disable iff (!rstN)
      stateQ[b] == DIR_E |-> $onehot(shareQ[b]));
    assert_busy_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
      busyQ[b] |-> stateQ[b] == DIR_E);
  end

  assert_sweep_emits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|scanVecQ) |=> msgValid && msgType == MSG_INV);
  assert_sweep_retry_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && (|scanVecQ) |=> rtyValid);
  assert_fwd_marks_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && msgType == MSG_FWD |-> busyQ[msgBlk]);

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_PROC = 4,
  parameter int NUM_BLK  = 8,
  parameter int DATA_W   = 16,
  localparam int ID_W    = $clog2(NUM_PROC),
  localparam int BLK_W   = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ID_W-1:0]   reqSrc,
  input  logic [BLK_W-1:0]  reqBlk,
  input  logic              ackValid,
  input  logic [BLK_W-1:0]  ackBlk,
  input  logic [DATA_W-1:0] ackData,
  output logic              msgValid,
  output logic [1:0]        msgType,
  output logic [ID_W-1:0]   msgDest,
  output logic [ID_W-1:0]   msgReq,
  output logic [BLK_W-1:0]  msgBlk,
  output logic [DATA_W-1:0] msgData,
  output logic              rtyValid,
  output logic [ID_W-1:0]   rtyDest,
  output logic [BLK_W-1:0]  rtyBlk
);

  dirCtl_t   ctl;
  dirState_e curState;
  logic      curBusy;
  logic      ackBusy;
  logic      scanActive;
  msgType_e  msgTypeE;

  dir_ctrl_decide u_decide (
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .curState  (curState),
    .curBusy   (curBusy),
    .scanActive(scanActive),
    .ackValid  (ackValid),
    .ackBusy   (ackBusy),
    .ctl       (ctl)
  );

  dir_ctrl_dp #(
    .NUM_PROC(NUM_PROC),
    .NUM_BLK (NUM_BLK),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqSrc    (reqSrc),
    .reqBlk    (reqBlk),
    .ackBlk    (ackBlk),
    .ackData   (ackData),
    .curState  (curState),
    .curBusy   (curBusy),
    .ackBusy   (ackBusy),
    .scanActive(scanActive),
    .msgValid  (msgValid),
    .msgType   (msgTypeE),
    .msgDest   (msgDest),
    .msgReq    (msgReq),
    .msgBlk    (msgBlk),
    .msgData   (msgData),
    .rtyValid  (rtyValid),
    .rtyDest   (rtyDest),
    .rtyBlk    (rtyBlk)
  );

  assign msgType = msgTypeE;

endmodule

// File: tb/dir_ctrl_tb_top.sv
module dir_ctrl_tb_top;

  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 16;
  localparam int IW = $clog2(NP);
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [IW-1:0] reqSrc = '0;
  logic [BW-1:0] reqBlk = '0;
  logic          ackValid = 1'b0;
  logic [BW-1:0] ackBlk = '0;
  logic [DW-1:0] ackData = '0;
  logic          msgValid;
  logic [1:0]    msgType;
  logic [IW-1:0] msgDest;
  logic [IW-1:0] msgReq;
  logic [BW-1:0] msgBlk;
  logic [DW-1:0] msgData;
  logic          rtyValid;
  logic [IW-1:0] rtyDest;
  logic [BW-1:0] rtyBlk;

  always #10 clk = ~clk;  // 50 MHz

  dir_ctrl #(.NUM_PROC(NP), .NUM_BLK(NB), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSrc(reqSrc), .reqBlk(reqBlk),
    .ackValid(ackValid), .ackBlk(ackBlk), .ackData(ackData),
    .msgValid(msgValid), .msgType(msgType), .msgDest(msgDest), .msgReq(msgReq),
    .msgBlk(msgBlk), .msgData(msgData),
    .rtyValid(rtyValid), .rtyDest(rtyDest), .rtyBlk(rtyBlk)
  );

  typedef struct {
    int due;
    int typ;
    int dest;
    int rq;
    int blk;
    int data;
    int tag;
  } exp_t;

  exp_t msgQ[$];
  exp_t rtyQ[$];
  int   cyc = 0;
  int   lastCyc = 0;
  int   compared = 0;
  int   mismatched = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- scoreboard monitor ----------------
  always @(negedge clk) begin
    if (rstN) begin
      if (msgQ.size() > 0 && msgQ[0].due == cyc) begin
        exp_t e;
        e = msgQ.pop_front();
        compared++;
        if (!msgValid || int'(msgType) != e.typ || int'(msgDest) != e.dest ||
            int'(msgReq) != e.rq || int'(msgBlk) != e.blk || int'(msgData) != e.data) begin
          mismatched++;
          $display("FAIL R%0d msg @%0d: got v=%0d t=%0d d=%0d r=%0d b=%0d x=%0h exp t=%0d d=%0d r=%0d b=%0d x=%0h",
                   e.tag, cyc, msgValid, msgType, msgDest, msgReq, msgBlk, msgData,
                   e.typ, e.dest, e.rq, e.blk, e.data);
        end
      end else if (msgValid) begin
        compared++; mismatched++;
        $display("FAIL unexpected msg @%0d: got t=%0d d=%0d b=%0d exp none", cyc, msgType, msgDest, msgBlk);
      end
      while (msgQ.size() > 0 && msgQ[0].due < cyc) begin
        exp_t e;
        e = msgQ.pop_front();
        compared++; mismatched++;
        $display("FAIL R%0d msg missing: got none exp t=%0d d=%0d b=%0d due %0d", e.tag, e.typ, e.dest, e.blk, e.due);
      end
      if (rtyQ.size() > 0 && rtyQ[0].due == cyc) begin
        exp_t e;
        e = rtyQ.pop_front();
        compared++;
        if (!rtyValid || int'(rtyDest) != e.dest || int'(rtyBlk) != e.blk) begin
          mismatched++;
          $display("FAIL R%0d retry @%0d: got v=%0d d=%0d b=%0d exp d=%0d b=%0d",
                   e.tag, cyc, rtyValid, rtyDest, rtyBlk, e.dest, e.blk);
        end
      end else if (rtyValid) begin
        compared++; mismatched++;
        $display("FAIL unexpected retry @%0d: got d=%0d b=%0d exp none", cyc, rtyDest, rtyBlk);
      end
      while (rtyQ.size() > 0 && rtyQ[0].due < cyc) begin
        exp_t e;
        e = rtyQ.pop_front();
        compared++; mismatched++;
        $display("FAIL R%0d retry missing: got none exp d=%0d b=%0d", e.tag, e.dest, e.blk);
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic sendReq(input bit wr, input int src, input int blk);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSrc = IW'(src); reqBlk = BW'(blk);
    lastCyc = cyc;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic sendAck(input int blk, input int data);
    @(negedge clk);
    ackValid = 1'b1; ackBlk = BW'(blk); ackData = DW'(data);
    @(posedge clk);
    #1 ackValid = 1'b0;
  endtask

  task automatic expMsg(input int tag, input int off, input int typ, input int dest,
                        input int rq, input int blk, input int data);
    exp_t e;
    e.due = lastCyc + off; e.typ = typ; e.dest = dest; e.rq = rq;
    e.blk = blk; e.data = data; e.tag = tag;
    msgQ.push_back(e);
  endtask

  task automatic expRty(input int tag, input int dest, input int blk);
    exp_t e;
    e.due = lastCyc + 1; e.typ = 0; e.dest = dest; e.rq = 0;
    e.blk = blk; e.data = 0; e.tag = tag;
    rtyQ.push_back(e);
  endtask

  task automatic checkQuiet(input int tag, input int off);
    while (cyc < lastCyc + off) @(negedge clk);
    compared++;
    if (msgValid) begin
      mismatched++;
      $display("FAIL R%0d quiet slot @%0d: got msgValid=1 t=%0d d=%0d exp 0", tag, cyc, msgType, msgDest);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam int T_DATA = 0, T_INV = 1, T_FWD = 2;

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired: got hang exp completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    compared++;
    if (msgValid || rtyValid) begin
      mismatched++;
      $display("FAIL R1 reset outputs: got msg=%0d rty=%0d exp 0 0", msgValid, rtyValid);
    end

    // R1, R2: first read of an Uncached block returns reset memory word
    sendReq(0, 0, 1); expMsg(2, 1, T_DATA, 0, 0, 1, 257);
    // R3: more readers join
    sendReq(0, 1, 1); expMsg(3, 1, T_DATA, 1, 1, 1, 257);
    sendReq(0, 3, 1); expMsg(3, 1, T_DATA, 3, 3, 1, 257);
    // R5: write by sharer 1 invalidates 0 then 3
    sendReq(1, 1, 1);
    expMsg(5, 1, T_DATA, 1, 1, 1, 257);
    expMsg(5, 2, T_INV, 0, 1, 1, 0);
    expMsg(5, 3, T_INV, 3, 1, 1, 0);
    // R9: request during the sweep is retried
    sendReq(0, 2, 5); expRty(9, 2, 5);
    idle(4);

    // R6: read to Exclusive block forwards to owner 1
    sendReq(0, 2, 1); expMsg(6, 1, T_FWD, 1, 2, 1, 0);
    // R8: request to busy block retried
    sendReq(0, 3, 1); expRty(8, 3, 1);
    sendAck(1, 16'hBEEF);
    // R10: stray ack to idle block 3
    sendAck(3, 16'h1111);
    // R6: memory updated, sharers are 1 and 2
    sendReq(1, 0, 1);
    expMsg(6, 1, T_DATA, 0, 0, 1, 16'hBEEF);
    expMsg(6, 2, T_INV, 1, 0, 1, 0);
    expMsg(6, 3, T_INV, 2, 0, 1, 0);
    idle(4);

    // R10: block 3 memory unchanged by the stray ack
    sendReq(0, 3, 3); expMsg(10, 1, T_DATA, 3, 3, 3, 259);
    // R4, R11: first write to Uncached block, no invalidate follows
    sendReq(1, 2, 4); expMsg(4, 1, T_DATA, 2, 2, 4, 260);
    checkQuiet(11, 2);

    // R7: write to Exclusive block forwards, requester becomes owner
    sendReq(1, 3, 4); expMsg(7, 1, T_FWD, 2, 3, 4, 0);
    sendAck(4, 16'h2222);
    sendReq(0, 0, 4); expMsg(7, 1, T_FWD, 3, 0, 4, 0);
    sendAck(4, 16'h3333);
    // R6: written-back data now in memory
    sendReq(0, 1, 4); expMsg(6, 1, T_DATA, 1, 1, 4, 16'h3333);

    // R5: sole sharer writing gets no invalidate of itself
    sendReq(0, 0, 2); expMsg(2, 1, T_DATA, 0, 0, 2, 258);
    sendReq(1, 0, 2); expMsg(5, 1, T_DATA, 0, 0, 2, 258);
    checkQuiet(5, 2);

    idle(6);
    finishRun();
  end

endmodule